// File: doc/BRIEF.md
# Gated Dual-Input Event Counter

This block counts rising edges on one of two asynchronous event inputs, a high-band input and a low-band input, and reports the total on a 20-bit registered output. A select bit picks the input that is counted. Both inputs are always synchronised to the system clock, and their edge pulses are multiplexed after edge detection.

An enable bit gates the whole block. While it is low, the count and the overflow flag are held at zero and both event inputs are seen as low. Setting it high starts a new count from zero. The result therefore has to be read while the enable bit is still high. The counter stops at its all-ones value and raises a sticky overflow flag if a further event arrives.

Top module: `gated_event_counter`

## Requirements
- R1: The count is a 20-bit unsigned binary value. It increases by exactly one for each rising edge of the selected input and never changes by more than one per clock.
- R2: While `cnt_en` is 0, `count` is 0 and `ovf` is 0 from the next clock edge on. Edges on either input have no effect.
- R3: With `sel_hi` = 1, only `evt_hi` is counted. With `sel_hi` = 0, only `evt_lo` is counted. Edges on the other input leave `count` unchanged.
- R4: A low-to-high change of the selected input, set up before clock edge k, shows on `count` after clock edge k+2 and not earlier: two synchroniser stages, then the count register.
- R5: Only rising edges are counted. A level held high for many cycles adds one, and a falling edge adds nothing.
- R6: Changing `sel_hi` while the two inputs stand at different levels produces no count. The next rising edge of the newly selected input is counted.
- R7: When an event arrives while `count` is all ones, `count` holds and `ovf` goes to 1. `ovf` stays 1 until `cnt_en` goes low or `rst` is applied. `ovf` is 1 only while `count` is all ones.
- R8: Synchronous active-high `rst` clears `count` and `ovf` at the next clock edge.
- R9: An input that is already high when `cnt_en` rises is counted once, because it was treated as low while the block was disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_hi | input | 1 | Asynchronous high-band event input |
| evt_lo | input | 1 | Asynchronous low-band event input |
| cnt_en | input | 1 | Enable; 0 holds the counter cleared |
| sel_hi | input | 1 | Source select: 1 = evt_hi, 0 = evt_lo |
| count | output | CNT_W (20) | Registered event count |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The assertions check, on every cycle, the following properties:
- Disabling the block clears it.
- The count moves by at most one per cycle.
- The count holds once it reaches all ones.
- The overflow flag stays set and appears only with an all-ones count.

Some behaviours can only be shown by the directed scenarios, because they depend on which input toggled and when:
- the exact three-edge latency;
- counting one edge for a long high level;
- rejecting edges on the unselected input;
- the absence of a count when the select changes;
- the single count for an input already high at enable.

Saturation is exercised on a narrow copy of the counter.

// File: rtl/gec_pkg.sv
package gec_pkg;
  typedef enum logic {
    SRC_LO = 1'b0,
    SRC_HI = 1'b1
  } src_e;

  localparam int unsigned GEC_NUM_SRC = 2;
endpackage

// File: rtl/gec_edge_detect.sv
module gec_edge_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic clear,
  input  logic din,
  output logic rise
);
  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] chain;
  logic                   last;

  always_ff @(posedge clk) begin
    if (clear) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[SYNC_STAGES-2:0], din};
      last  <= chain[TOP];
    end
  end

  assign rise = chain[TOP] & ~last;
endmodule

// File: rtl/gec_sat_counter.sv
module gec_sat_counter #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic at_max;
  assign at_max = (count == CNT_MAX);

  always_ff @(posedge clk) begin
    if (clear) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (step) begin
      if (at_max) begin
        ovf <= 1'b1;
      end else begin
        count <= count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gated_event_counter.sv
module gated_event_counter
  import gec_pkg::*;
#(
  parameter int unsigned CNT_W       = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_hi,
  input  logic             evt_lo,
  input  logic             cnt_en,
  input  logic             sel_hi,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  logic                   clear;
  logic [GEC_NUM_SRC-1:0] evt_in;
  logic [GEC_NUM_SRC-1:0] rise;
  logic                   step;
  src_e                   src;

  // The enable bit acts as a synchronous clear of every stage.
  assign clear  = rst | ~cnt_en;
  assign evt_in = {evt_hi, evt_lo};
  assign src    = src_e'(sel_hi);

  for (genvar ch = 0; ch < GEC_NUM_SRC; ch++) begin : g_chan
    gec_edge_detect #(
      .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
      .clk  (clk),
      .clear(clear),
      .din  (evt_in[ch]),
      .rise (rise[ch])
    );
  end

  // Select edge pulses, not levels, so a select change cannot form an edge.
  assign step = (src == SRC_HI) ? rise[1] : rise[0];

  gec_sat_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk  (clk),
    .clear(clear),
    .step (step),
    .count(count),
    .ovf  (ovf)
  );
endmodule

// File: rtl/gec_checker.sv
module gec_checker #(
  parameter int unsigned CNT_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_en,
  input logic [CNT_W-1:0] count,
  input logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assert_disable_clears_R2: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> (count == '0) && !ovf);

  assert_step_one_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> (count == $past(count)) || (count == $past(count) + 1'b1));

  assert_hold_at_max_R7: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count == CNT_MAX) |=> count == CNT_MAX);

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && ovf) |=> ovf);

  assert_ovf_at_max_R7: assert property (@(posedge clk) disable iff (rst)
    ovf |-> count == CNT_MAX);

  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> (count == '0) && !ovf);
endmodule

bind gated_event_counter gec_checker #(
  .CNT_W(CNT_W)
) u_gec_checker (
  .clk   (clk),
  .rst   (rst),
  .cnt_en(cnt_en),
  .count (count),
  .ovf   (ovf)
);

// File: tb/test_gated_event_counter.sv
module test_gated_event_counter;
  localparam int unsigned W_WIDE   = 20;
  localparam int unsigned W_NARROW = 4;
  localparam int unsigned N_MAX    = (1 << W_NARROW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evt_hi = 1'b0;
  logic evt_lo = 1'b0;
  logic cnt_en = 1'b0;
  logic sel_hi = 1'b0;
  logic [W_WIDE-1:0]   count_w;
  logic [W_NARROW-1:0] count_n;
  logic ovf_w, ovf_n;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  gated_event_counter i_gated_event_counter (
    .clk(clk), .rst(rst), .evt_hi(evt_hi), .evt_lo(evt_lo),
    .cnt_en(cnt_en), .sel_hi(sel_hi), .count(count_w), .ovf(ovf_w)
  );

  gated_event_counter #(.CNT_W(W_NARROW)) i_gated_event_counter_narrow (
    .clk(clk), .rst(rst), .evt_hi(evt_hi), .evt_lo(evt_lo),
    .cnt_en(cnt_en), .sel_hi(sel_hi), .count(count_n), .ovf(ovf_n)
  );

  task automatic check(input string req, input int actual, input int expected);
    n_checks++;
    if (actual !== expected) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit hi);
    @(negedge clk);
    if (hi) evt_hi = 1'b1; else evt_lo = 1'b1;
    cycles(3);
    if (hi) evt_hi = 1'b0; else evt_lo = 1'b0;
    cycles(3);
  endtask

  task automatic restart(input bit sel);
    @(negedge clk);
    cnt_en = 1'b0;
    cycles(2);
    sel_hi = sel;
    cnt_en = 1'b1;
    cycles(1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    cycles(2);
    check("R8 count after reset", int'(count_w), 0);
    check("R8 ovf after reset", int'(ovf_w), 0);
    rst = 1'b0;
    restart(1'b1);
    pulse(1'b1); pulse(1'b1); pulse(1'b1);
    check("R8 count before mid reset", int'(count_w), 3);
    rst = 1'b1;
    cycles(1);
    rst = 1'b0;
    check("R8 mid-count reset", int'(count_w), 0);
  endtask

  task automatic t_select_inputs();
    restart(1'b1);
    for (int i = 0; i < 5; i++) pulse(1'b1);
    check("R3 hi input counted", int'(count_w), 5);
    for (int i = 0; i < 3; i++) pulse(1'b0);
    check("R3 lo edges ignored when hi selected", int'(count_w), 5);
    restart(1'b0);
    for (int i = 0; i < 4; i++) pulse(1'b0);
    check("R3 lo input counted", int'(count_w), 4);
    pulse(1'b1); pulse(1'b1);
    check("R3 hi edges ignored when lo selected", int'(count_w), 4);
  endtask

  task automatic t_latency();
    restart(1'b1);
    cycles(2);
    evt_hi = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R4 no change after two edges", int'(count_w), 0);
    @(negedge clk);
    check("R4 change after third edge", int'(count_w), 1);
    evt_hi = 1'b0;
    cycles(4);
  endtask

  task automatic t_level();
    restart(1'b1);
    @(negedge clk);
    evt_hi = 1'b1;
    cycles(20);
    check("R5 long high level counts once", int'(count_w), 1);
    evt_hi = 1'b0;
    cycles(6);
    check("R5 falling edge not counted", int'(count_w), 1);
  endtask

  task automatic t_switch();
    restart(1'b0);
    @(negedge clk);
    evt_hi = 1'b1;
    cycles(6);
    sel_hi = 1'b1;
    cycles(6);
    check("R6 switch to high input no count", int'(count_w), 0);
    sel_hi = 1'b0;
    cycles(6);
    check("R6 switch back no count", int'(count_w), 0);
    evt_hi = 1'b0;
    pulse(1'b0);
    check("R6 next selected edge counted", int'(count_w), 1);
  endtask

  task automatic t_disable();
    restart(1'b1);
    pulse(1'b1); pulse(1'b1);
    check("R2 count before disable", int'(count_w), 2);
    cnt_en = 1'b0;
    cycles(1);
    check("R2 disable clears count", int'(count_w), 0);
    pulse(1'b1); pulse(1'b0);
    check("R2 edges ignored when disabled", int'(count_w), 0);
  endtask

  task automatic t_enable_high();
    @(negedge clk);
    cnt_en = 1'b0;
    sel_hi = 1'b1;
    evt_hi = 1'b1;
    cycles(3);
    cnt_en = 1'b1;
    cycles(8);
    check("R9 input high at enable counted once", int'(count_w), 1);
    evt_hi = 1'b0;
    cycles(4);
  endtask

  task automatic t_saturate();
    restart(1'b0);
    for (int i = 0; i < N_MAX; i++) pulse(1'b0);
    check("R7 narrow reaches max", int'(count_n), N_MAX);
    check("R7 no ovf at max", int'(ovf_n), 0);
    pulse(1'b0);
    check("R7 holds at max", int'(count_n), N_MAX);
    check("R7 ovf set", int'(ovf_n), 1);
    pulse(1'b0); pulse(1'b0);
    check("R7 ovf sticky", int'(ovf_n), 1);
    check("R1 wide counter keeps counting", int'(count_w), N_MAX + 3);
    check("R1 width is 20 bits", $bits(count_w), 20);
    @(negedge clk);
    cnt_en = 1'b0;
    cycles(1);
    check("R7 ovf cleared by disable", int'(ovf_n), 0);
    check("R7 count cleared by disable", int'(count_n), 0);
  endtask

  initial begin
    cycles(100000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    cycles(3);
    t_reset();
    t_select_inputs();
    t_latency();
    t_level();
    t_switch();
    t_disable();
    t_enable_high();
    t_saturate();
    summary();
  end
endmodule